// File: doc/BRIEF.md
# Infrared Serial Pulse Shaper

This block sits between a UART's serial line and an external infrared transceiver. On the transmit side it watches the UART's NRZ output and emits a short, fixed-width LED pulse at the start of every bit cell that carries a zero. Start bits and data zeros are pulsed, and ones and idle time leave the LED dark. The pulse width is a fixed number of core clock cycles. With the default of 6 cycles at a 3.6864 MHz core clock, a pulse lasts 3/16 of a 115200 bit/s bit time. This width does not change with the programmed baud rate.

On the receive side the transceiver delivers an active-low pulse for every received zero. The block passes that line through a two-flop synchronizer, detects falling edges and holds its NRZ output low for one full bit time, measured in ticks of the 16x baud enable. A fresh edge restarts the stretch. The UART receiver then sees ordinary full-width zero bits.

A software reset input clears the shaping logic synchronously. The active-low hardware reset clears it asynchronously. A registered, active-low transceiver shutdown output is also provided, and it can serve as a general-purpose output.

Top module: `irsir_shaper`

## Requirements
- R1: Every LED pulse on `ir_tx` (1 = LED on) stays high for exactly PULSE_CYC consecutive clock cycles (default 6), independent of the baud enable rate.
- R2: `ir_tx` is low whenever no pulse is being emitted. A `tx_nrz` held at 1, whether idle or a data one, never produces a pulse.
- R3: A falling edge on `tx_nrz` starts a pulse at the first clock edge that sees the low level. That edge also opens a bit cell of OVS baud ticks (default 16), and the tick present on that edge counts as the first tick. At the first clock edge after the cell's last tick, a low `tx_nrz` starts another pulse. Consecutive zero cells therefore each get one pulse.
- R4: `soft_rst` high at a clock edge clears the shaper at that edge, so `ir_tx`=0 and `rx_nrz`=1 afterwards. `rst_n` low does the same asynchronously and also drives `ir_sd_n` to 0.
- R5: `ir_rx_n` passes through a two-flop synchronizer. A low level sampled at edge E1, following a high level, drives `rx_nrz` low after edge E3.
- R6: After the stretch is loaded, `rx_nrz` stays low for exactly STRETCH baud ticks (default 16). A tick on the load edge is not counted. `rx_nrz` returns high at the edge of the last tick. With a tick every cycle, `rx_nrz` is low for 16 cycles.
- R7: A new falling edge on the synchronized receive line during a stretch reloads the full STRETCH count.
- R8: `ir_sd_n` is a registered copy of `xcvr_on` with one clock of latency (1 = transceiver enabled). It resets to 0 and is not affected by `soft_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (3.6864 MHz nominal) |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous shaper reset, active high |
| baud16_en | input | 1 | One-cycle enable at 16x the baud rate |
| tx_nrz | input | 1 | UART serial output, NRZ, idle high |
| ir_tx | output | 1 | LED drive to the transceiver, high = LED on |
| ir_rx_n | input | 1 | Receive line from the transceiver, low = pulse |
| rx_nrz | output | 1 | Stretched NRZ data to the UART receiver |
| xcvr_on | input | 1 | Control bit: 1 enables the transceiver |
| ir_sd_n | output | 1 | Transceiver shutdown, active low |

## Verification
The bench builds the block with its default parameters: a 6-cycle pulse, 16 ticks per bit cell and a 16-tick receive stretch. It runs transmit frames with a baud tick every second clock, so each bit cell spans 32 clocks. This keeps a pulse well inside its cell, so the frame table can check both the pulse count and every pulse width. Receive tests switch the tick to every clock, which turns the stretch length and the retrigger extension into exact cycle counts of 16 and 24.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
    // default shaping parameters for a 3.6864 MHz core clock
    parameter int unsigned IR_OVS_DEF     = 16;  // baud ticks per bit cell
    parameter int unsigned IR_PULSE_DEF   = 6;   // LED pulse width in clocks
    parameter int unsigned IR_STRETCH_DEF = 16;  // receive stretch in ticks
    parameter int unsigned IR_SYNC_DEF    = 2;   // synchronizer depth

    // width of a down-counter that must hold the value n
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
        if (clr) begin
            sh_d = {STAGES{RST_VAL}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/irsir_tx_shaper.sv
module irsir_tx_shaper
    import irsir_pkg::*;
#(
    parameter int unsigned OVS       = IR_OVS_DEF,
    parameter int unsigned PULSE_CYC = IR_PULSE_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic tx_nrz,
    output logic led
);
    localparam int unsigned PHW = (OVS < 2) ? 1 : $clog2(OVS);
    localparam int unsigned PCW = cnt_w(PULSE_CYC);
    localparam logic [PHW-1:0] PH_LAST = PHW'(OVS - 1);
    localparam logic [PHW-1:0] PH_ONE  = PHW'(1);
    localparam logic [PCW-1:0] PW_LOAD = PCW'(PULSE_CYC);

    typedef struct packed {
        logic           prev;   // tx level at the previous edge
        logic [PHW-1:0] phase;  // ticks elapsed in the current cell
        logic           bound;  // a cell ended at the previous edge
        logic [PCW-1:0] pcnt;   // remaining pulse cycles
        logic           led;    // registered LED drive
    } tx_st_t;

    localparam tx_st_t TX_RST = '{prev: 1'b1, phase: '0, bound: 1'b0,
                                  pcnt: '0, led: 1'b0};

    tx_st_t s_d, s_q;
    logic   fall, fire;

    always_comb begin
        s_d       = s_q;
        s_d.prev  = tx_nrz;
        s_d.bound = 1'b0;
        fall      = s_q.prev & ~tx_nrz;
        fire      = fall | (s_q.bound & ~tx_nrz);

        // bit cell tracking, realigned on every start edge
        if (fall) begin
            s_d.phase = tick ? PH_ONE : '0;
        end else if (tick) begin
            if (s_q.phase == PH_LAST) begin
                s_d.phase = '0;
                s_d.bound = 1'b1;
            end else begin
                s_d.phase = s_q.phase + PH_ONE;
            end
        end

        // fixed-width pulse timer in core clocks
        if (fire) begin
            s_d.pcnt = PW_LOAD;
        end else if (s_q.pcnt != '0) begin
            s_d.pcnt = s_q.pcnt - 1'b1;
        end
        s_d.led = (s_d.pcnt != '0);

        if (clr) begin
            s_d = TX_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= TX_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign led = s_q.led;
endmodule

// File: rtl/irsir_rx_stretch.sv
module irsir_rx_stretch
    import irsir_pkg::*;
#(
    parameter int unsigned STRETCH = IR_STRETCH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic rx_lvl,
    output logic nrz
);
    localparam int unsigned SCW = cnt_w(STRETCH);
    localparam logic [SCW-1:0] ST_LOAD = SCW'(STRETCH);

    typedef struct packed {
        logic           prev;  // synchronized level at the previous edge
        logic [SCW-1:0] cnt;   // ticks left in the stretch
        logic           nrz;   // registered output
    } rx_st_t;

    localparam rx_st_t RX_RST = '{prev: 1'b1, cnt: '0, nrz: 1'b1};

    rx_st_t s_d, s_q;
    logic   fall;

    always_comb begin
        s_d      = s_q;
        s_d.prev = rx_lvl;
        fall     = s_q.prev & ~rx_lvl;

        if (fall) begin
            s_d.cnt = ST_LOAD;
        end else if (tick && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        s_d.nrz = (s_d.cnt == '0);

        if (clr) begin
            s_d = RX_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RX_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign nrz = s_q.nrz;
endmodule

// File: rtl/irsir_shaper.sv
module irsir_shaper
    import irsir_pkg::*;
#(
    parameter int unsigned OVS       = IR_OVS_DEF,
    parameter int unsigned PULSE_CYC = IR_PULSE_DEF,
    parameter int unsigned STRETCH   = IR_STRETCH_DEF,
    parameter int unsigned SYNC_FF   = IR_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic baud16_en,
    input  logic tx_nrz,
    output logic ir_tx,
    input  logic ir_rx_n,
    output logic rx_nrz,
    input  logic xcvr_on,
    output logic ir_sd_n
);
    typedef struct packed {
        logic sd_n;
    } top_st_t;

    top_st_t t_d, t_q;
    logic    rx_sync;

    irsir_tx_shaper #(.OVS(OVS), .PULSE_CYC(PULSE_CYC)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .tick   (baud16_en),
        .tx_nrz (tx_nrz),
        .led    (ir_tx)
    );

    irsir_sync #(.STAGES(SYNC_FF), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .d     (ir_rx_n),
        .q     (rx_sync)
    );

    irsir_rx_stretch #(.STRETCH(STRETCH)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .tick   (baud16_en),
        .rx_lvl (rx_sync),
        .nrz    (rx_nrz)
    );

    // shutdown pin is a plain output register outside the shaper reset
    always_comb begin
        t_d      = t_q;
        t_d.sd_n = xcvr_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{sd_n: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign ir_sd_n = t_q.sd_n;
endmodule

// File: rtl/irsir_checker.sv
module irsir_checker #(
    parameter int unsigned PULSE_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic baud16_en,
    input logic tx_nrz,
    input logic ir_tx,
    input logic ir_rx_n,
    input logic rx_nrz,
    input logic xcvr_on,
    input logic ir_sd_n
);
    int unsigned hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
        end else if (ir_tx) begin
            hi_run <= hi_run + 1;
        end else begin
            hi_run <= 0;
        end
    end

    // R1: a pulse that ends on its own lasted exactly PULSE_CYC clocks
    p_pulse_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_tx) && !$past(soft_rst)) |-> (hi_run == PULSE_CYC));

    // R2: the LED only turns on when the serial line carried a zero
    p_led_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx) |-> !$past(tx_nrz));

    // R4: soft reset leaves the LED dark and the receive output idle
    p_soft_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (!ir_tx && rx_nrz));

    // R5: a stretch begins three edges after the low level was sampled
    p_rx_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_nrz) |-> !$past(ir_rx_n, 3));

    // R6: a stretch ends only on a baud tick
    p_rx_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_nrz) && !$past(soft_rst)) |-> $past(baud16_en));

    // R8: shutdown pin follows its control one clock later
    p_sd_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_on |=> ir_sd_n);
    p_sd_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_on |=> !ir_sd_n);
endmodule

bind irsir_shaper irsir_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .baud16_en (baud16_en),
    .tx_nrz    (tx_nrz),
    .ir_tx     (ir_tx),
    .ir_rx_n   (ir_rx_n),
    .rx_nrz    (rx_nrz),
    .xcvr_on   (xcvr_on),
    .ir_sd_n   (ir_sd_n)
);

// File: tb/sim_irsir_shaper.sv
`timescale 1ns/1ps
module sim_irsir_shaper;
    localparam int PW  = 6;
    localparam int OVS = 16;

    // frame table: {data byte, expected pulse count incl. start bit}
    localparam logic [15:0] TXV [8] = '{
        16'h00_09, 16'hFF_01, 16'h55_05, 16'hA5_05,
        16'h80_08, 16'h01_08, 16'h3C_05, 16'h7E_03
    };

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, baud16_en = 1'b0;
    logic tx_nrz = 1'b1, ir_rx_n = 1'b1, xcvr_on = 1'b0;
    logic ir_tx, rx_nrz, ir_sd_n;

    int n_chk = 0, n_fail = 0;
    int tick_div = 2, div_cnt = 0;
    int mon_rises = 0, mon_bad = 0, mon_run = 0;
    logic mon_last = 1'b0;
    bit done = 1'b0;

    irsir_shaper u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud16_en(baud16_en),
        .tx_nrz(tx_nrz), .ir_tx(ir_tx), .ir_rx_n(ir_rx_n), .rx_nrz(rx_nrz),
        .xcvr_on(xcvr_on), .ir_sd_n(ir_sd_n)
    );

    always #5 clk = ~clk;

    // baud tick generator, changes away from the active edge
    always @(negedge clk) begin
        if (div_cnt + 1 >= tick_div) begin
            div_cnt   = 0;
            baud16_en = 1'b1;
        end else begin
            div_cnt   = div_cnt + 1;
            baud16_en = 1'b0;
        end
    end

    // LED pulse monitor
    always @(negedge clk) begin
        if (ir_tx && !mon_last) mon_rises = mon_rises + 1;
        if (ir_tx) begin
            mon_run = mon_run + 1;
        end else if (mon_last) begin
            if (mon_run != PW) mon_bad = mon_bad + 1;
            mon_run = 0;
        end
        mon_last = ir_tx;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // drive one bit cell of OVS ticks
    task automatic drive_bit(input logic b);
        int n = 0;
        @(negedge clk) tx_nrz = b;
        while (n < OVS) begin
            @(posedge clk);
            if (baud16_en) n = n + 1;
        end
    endtask

    task automatic send_frame(input logic [7:0] b);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(1'b1);
        repeat (10) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_rises = 0;
        mon_bad   = 0;
    endtask

    // receive pulse of two clocks, optional second pulse at negedge index k2
    task automatic rx_run(input int k2, output int low);
        int k = 3;
        low = 0;
        @(negedge clk) ir_rx_n = 1'b0;
        @(negedge clk);
        @(negedge clk) ir_rx_n = 1'b1;
        check(rx_nrz == 1'b1, "R5 not low before third edge", rx_nrz, 1);
        @(negedge clk);
        check(rx_nrz == 1'b0, "R5 low after third edge", rx_nrz, 0);
        while (rx_nrz == 1'b0 && low < 200) begin
            low = low + 1;
            if (k2 != 0 && k == k2) ir_rx_n = 1'b0;
            if (k2 != 0 && k == k2 + 2) ir_rx_n = 1'b1;
            @(negedge clk);
            k = k + 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk  = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int low;
        repeat (4) @(negedge clk);
        // R4: reset state
        check(ir_tx == 1'b0, "R4 reset ir_tx", ir_tx, 0);
        check(rx_nrz == 1'b1, "R4 reset rx_nrz", rx_nrz, 1);
        check(ir_sd_n == 1'b0, "R4 reset ir_sd_n", ir_sd_n, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // R1 R3: frame table
        foreach (TXV[i]) begin
            clear_mon();
            send_frame(TXV[i][15:8]);
            check(mon_rises == int'(TXV[i][7:0]), "R3 frame pulse count",
                  mon_rises, int'(TXV[i][7:0]));
            check(mon_bad == 0, "R1 frame pulse width", mon_bad, 0);
        end

        // R2: long idle stays dark
        clear_mon();
        repeat (150) @(negedge clk);
        check(mon_rises == 0, "R2 idle pulses", mon_rises, 0);

        // R3: pulse starts at the first edge seeing the start level
        @(negedge clk) tx_nrz = 1'b0;
        check(ir_tx == 1'b0, "R3 no pulse before edge", ir_tx, 0);
        @(negedge clk);
        check(ir_tx == 1'b1, "R3 start pulse latency", ir_tx, 1);
        // R4: soft reset in mid pulse
        soft_rst = 1'b1;
        tx_nrz   = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        check(ir_tx == 1'b0, "R4 soft reset clears pulse", ir_tx, 0);
        repeat (80) @(negedge clk);

        // R3: break of three zero cells gives three pulses
        clear_mon();
        drive_bit(1'b0);
        drive_bit(1'b0);
        drive_bit(1'b0);
        drive_bit(1'b1);
        check(mon_rises == 3, "R3 consecutive zero cells", mon_rises, 3);
        check(mon_bad == 0, "R1 break pulse width", mon_bad, 0);

        // R5 R6: single receive pulse, tick every clock
        tick_div = 1;
        repeat (5) @(negedge clk);
        rx_run(0, low);
        check(low == 16, "R6 stretch length", low, 16);
        repeat (10) @(negedge clk);
        // R7: retrigger during stretch
        rx_run(8, low);
        check(low == 24, "R7 retrigger length", low, 24);
        repeat (10) @(negedge clk);

        // R4: soft reset releases a stretch
        @(negedge clk) ir_rx_n = 1'b0;
        repeat (4) @(negedge clk);
        ir_rx_n = 1'b1;
        check(rx_nrz == 1'b0, "R4 stretch active", rx_nrz, 0);
        soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        check(rx_nrz == 1'b1, "R4 soft reset clears stretch", rx_nrz, 1);
        repeat (30) @(negedge clk);
        check(rx_nrz == 1'b1, "R4 stays idle after soft reset", rx_nrz, 1);

        // R8: shutdown output
        xcvr_on = 1'b1;
        check(ir_sd_n == 1'b0, "R8 latency", ir_sd_n, 0);
        @(negedge clk);
        check(ir_sd_n == 1'b1, "R8 follows control", ir_sd_n, 1);
        soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        check(ir_sd_n == 1'b1, "R8 ignores soft reset", ir_sd_n, 1);
        xcvr_on = 1'b0;
        @(negedge clk);
        check(ir_sd_n == 1'b0, "R8 follows control low", ir_sd_n, 0);
        xcvr_on = 1'b1;

        // R4: hardware reset during activity
        tick_div = 2;
        @(negedge clk) ir_rx_n = 1'b0;
        repeat (4) @(negedge clk);
        ir_rx_n = 1'b1;
        rst_n   = 1'b0;
        @(negedge clk);
        check(rx_nrz == 1'b1, "R4 hw reset rx_nrz", rx_nrz, 1);
        check(ir_sd_n == 1'b0, "R4 hw reset ir_sd_n", ir_sd_n, 0);
        check(ir_tx == 1'b0, "R4 hw reset ir_tx", ir_tx, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);

        finish_run();
    end
endmodule